// File: doc/BRIEF.md
# Circular Result-Tag Allocator with In-Order Retirement

This block hands out result-buffer slot numbers as tags for the nodes of each new instruction, and it retires those instructions strictly in program order. Each slot number is also the address of the result-buffer entry that will hold the node's value. A request names how many nodes the instruction needs. When the request is granted, the block returns that many consecutive slot numbers, taken from a circular pointer that wraps at the slot count. The instruction then joins a window of in-flight instructions.

Functional units report finished nodes by tag on one or more completion ports. An instruction is executed once every one of its nodes has been reported. It retires only when it is executed and sits at the head of the window, so every older instruction has already gone. On retirement the block raises a strobe carrying the instruction's first tag and node count, which downstream logic uses to commit buffered memory writes. The same clock edge returns the instruction's slots to the free pool.

A request stalls when the pool lacks enough free slots for it or when the window is full. Because slots leave the pool only in order, the in-flight slots always form one contiguous arc of the ring, ending just before the allocation pointer.

Top module: `tagq_alloc`

## Requirements
- R1: After reset every slot is free, the window is empty, no retire strobe is raised, and the first granted request receives tags starting at 0.
- R2: A granted request for N nodes receives tags T, T+1, ... T+N-1 modulo NUM_SLOTS on lanes 0..N-1 of `alloc_tags` (lane i in bits i*TAG_W upward), where T follows the last tag handed out; the tag after NUM_SLOTS-1 is 0.
- R3: `alloc_stall` is high only while `alloc_req` is high, and it is high when the requested count exceeds the number of free slots; a stalled request consumes nothing, so the next grant starts at the same tag.
- R4: `alloc_stall` is high for a request while WIN_DEPTH instructions are in flight, whatever the free slot count.
- R5: An instruction is not retired until every one of its tags has been reported complete; completions may arrive in any order.
- R6: Instructions retire in the order their requests were granted; an executed younger instruction waits for every older one.
- R7: At most one instruction retires per cycle. `retire_valid` is high in the cycle after the edge that recorded the last missing completion of the oldest instruction (or the edge on which it became oldest), with `retire_base` its first tag and `retire_cnt` its node count.
- R8: The slots and window entry of a retiring instruction become free at the clock edge that ends the retire cycle, and a request in the next cycle may use them.
- R9: Completions presented on several completion ports in the same cycle are all recorded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_req | input | 1 | Request tags for one instruction |
| alloc_cnt | input | CNT_W | Number of nodes, 1..MAX_NODES |
| alloc_stall | output | 1 | Request cannot be granted this cycle |
| alloc_tags | output | MAX_NODES*TAG_W | Granted tags, lane i is node i |
| cpl_valid | input | NUM_CPL | Completion report valid, one bit per port |
| cpl_tag | input | NUM_CPL*TAG_W | Tag of the completed node, one lane per port |
| retire_valid | output | 1 | Oldest instruction retires this cycle (commit pulse) |
| retire_base | output | TAG_W | First tag of the retiring instruction |
| retire_cnt | output | CNT_W | Node count of the retiring instruction |

## Verification
The assertions rely on three things about the inputs: a request count lies between 1 and MAX_NODES, a completion tag lies below NUM_SLOTS, and each completion names a slot that is in flight and not yet reported. The bench holds a model of the allocation pointer, free count, window and per-slot state. It draws completions only from slots that the model shows in flight and not yet done, and it never reports the same slot on two ports at once. Request counts are always drawn from 1..MAX_NODES, so every directed and swept pattern stays inside those limits.

// File: rtl/tagq_pkg.sv
package tagq_pkg;

   // Modular add on a ring of n entries; b must be below n.
   function automatic int ring_add(input int a, input int b, input int n);
      int s;
      s = a + b;
      if (s >= n) s = s - n;
      return s;
   endfunction

   // Distance going forward from "from" to "to" on a ring of n entries.
   function automatic int ring_dist(input int from, input int to, input int n);
      int d;
      d = to - from;
      if (d < 0) d = d + n;
      return d;
   endfunction

endpackage

// File: rtl/tagq_ring.sv
module tagq_ring
   import tagq_pkg::*;
#(
   parameter int NUM_SLOTS = 136,
   parameter int MAX_NODES = 4,
   parameter int TAG_W     = $clog2(NUM_SLOTS),
   parameter int CNT_W     = $clog2(MAX_NODES + 1),
   parameter int FREE_W    = $clog2(NUM_SLOTS + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       take_en,
   input  logic [CNT_W-1:0]           take_cnt,
   input  logic                       give_en,
   input  logic [CNT_W-1:0]           give_cnt,
   output logic [TAG_W-1:0]           ptr,
   output logic [MAX_NODES*TAG_W-1:0] lane_tags,
   output logic [FREE_W-1:0]          free_cnt
);

   localparam bit IS_POW2 = (NUM_SLOTS == (1 << TAG_W));

   logic [TAG_W-1:0]  ptr_q, ptr_nxt;
   logic [FREE_W-1:0] free_q, add_v, sub_v;

   generate
      if (IS_POW2) begin : g_mask_wrap
         for (genvar i = 0; i < MAX_NODES; i++) begin : g_lane
            assign lane_tags[i*TAG_W +: TAG_W] = ptr_q + TAG_W'(i);
         end
         assign ptr_nxt = ptr_q + TAG_W'(take_cnt);
      end else begin : g_cmp_wrap
         for (genvar i = 0; i < MAX_NODES; i++) begin : g_lane
            assign lane_tags[i*TAG_W +: TAG_W] =
               TAG_W'(ring_add(int'(ptr_q), i, NUM_SLOTS));
         end
         assign ptr_nxt = TAG_W'(ring_add(int'(ptr_q), int'(take_cnt), NUM_SLOTS));
      end
   endgenerate

   always_comb begin
      add_v = give_en ? FREE_W'(give_cnt) : '0;
      sub_v = take_en ? FREE_W'(take_cnt) : '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q  <= '0;
         free_q <= FREE_W'(NUM_SLOTS);
      end else begin
         if (take_en) ptr_q <= ptr_nxt;
         free_q <= free_q + add_v - sub_v;
      end
   end

   assign ptr      = ptr_q;
   assign free_cnt = free_q;

   AST_FREE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      free_q <= FREE_W'(NUM_SLOTS)); // R3

   AST_TAKE_FITS: assert property (@(posedge clk) disable iff (!rst_n)
      take_en |-> (FREE_W'(take_cnt) <= free_q)); // R3

endmodule

// File: rtl/tagq_done.sv
module tagq_done
   import tagq_pkg::*;
#(
   parameter int NUM_SLOTS = 136,
   parameter int NUM_CPL   = 2,
   parameter int TAG_W     = $clog2(NUM_SLOTS),
   parameter int CNT_W     = 3
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr_en,
   input  logic [TAG_W-1:0]         clr_base,
   input  logic [CNT_W-1:0]         clr_cnt,
   input  logic [NUM_CPL-1:0]       cpl_valid,
   input  logic [NUM_CPL*TAG_W-1:0] cpl_tag,
   output logic [NUM_SLOTS-1:0]     done
);

   generate
      for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
         logic hit, wipe, bit_q;

         always_comb begin
            hit = 1'b0;
            for (int k = 0; k < NUM_CPL; k++) begin
               if (cpl_valid[k] && (cpl_tag[k*TAG_W +: TAG_W] == TAG_W'(s)))
                  hit = 1'b1;
            end
            wipe = clr_en &&
                   (ring_dist(int'(clr_base), s, NUM_SLOTS) < int'(clr_cnt));
         end

         always_ff @(posedge clk) begin
            if (!rst_n)     bit_q <= 1'b0;
            else if (wipe)  bit_q <= 1'b0;
            else if (hit)   bit_q <= 1'b1;
         end

         assign done[s] = bit_q;
      end

      for (genvar k = 0; k < NUM_CPL; k++) begin : g_port_chk
         AST_CPL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            cpl_valid[k] |-> (int'(cpl_tag[k*TAG_W +: TAG_W]) < NUM_SLOTS)); // R9

         AST_CPL_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
            cpl_valid[k] |-> !done[cpl_tag[k*TAG_W +: TAG_W]]); // R5
      end
   endgenerate

endmodule

// File: rtl/tagq_window.sv
module tagq_window #(
   parameter int WIN_DEPTH = 16,
   parameter int TAG_W     = 8,
   parameter int CNT_W     = 3,
   parameter int PTR_W     = $clog2(WIN_DEPTH),
   parameter int OCC_W     = $clog2(WIN_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [TAG_W-1:0] push_base,
   input  logic [CNT_W-1:0] push_cnt,
   input  logic             pop,
   output logic             head_valid,
   output logic [TAG_W-1:0] head_base,
   output logic [CNT_W-1:0] head_cnt,
   output logic             full
);

   logic [TAG_W-1:0] base_q [WIN_DEPTH];
   logic [CNT_W-1:0] cnt_q  [WIN_DEPTH];
   logic [PTR_W-1:0] head_q, tail_q;
   logic [OCC_W-1:0] occ_q;

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(WIN_DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         occ_q  <= '0;
      end else begin
         if (push) tail_q <= bump(tail_q);
         if (pop)  head_q <= bump(head_q);
         occ_q <= occ_q + OCC_W'(push) - OCC_W'(pop);
      end
   end

   always_ff @(posedge clk) begin
      if (push) begin
         base_q[tail_q] <= push_base;
         cnt_q[tail_q]  <= push_cnt;
      end
   end

   assign head_valid = (occ_q != '0);
   assign head_base  = base_q[head_q];
   assign head_cnt   = cnt_q[head_q];
   assign full       = (occ_q == OCC_W'(WIN_DEPTH));

   AST_WIN_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full); // R4

   AST_WIN_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> head_valid); // R6

   AST_WIN_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      occ_q <= OCC_W'(WIN_DEPTH)); // R4

endmodule

// File: rtl/tagq_alloc.sv
module tagq_alloc
   import tagq_pkg::*;
#(
   parameter int NUM_SLOTS = 136,
   parameter int WIN_DEPTH = 16,
   parameter int MAX_NODES = 4,
   parameter int NUM_CPL   = 2,
   parameter int TAG_W     = $clog2(NUM_SLOTS),
   parameter int CNT_W     = $clog2(MAX_NODES + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       alloc_req,
   input  logic [CNT_W-1:0]           alloc_cnt,
   output logic                       alloc_stall,
   output logic [MAX_NODES*TAG_W-1:0] alloc_tags,
   input  logic [NUM_CPL-1:0]         cpl_valid,
   input  logic [NUM_CPL*TAG_W-1:0]   cpl_tag,
   output logic                       retire_valid,
   output logic [TAG_W-1:0]           retire_base,
   output logic [CNT_W-1:0]           retire_cnt
);

   localparam int FREE_W = $clog2(NUM_SLOTS + 1);

   generate
      if (NUM_SLOTS < 2)         begin : g_bad_slots  $error("NUM_SLOTS must be at least 2"); end
      if (WIN_DEPTH < 2)         begin : g_bad_win    $error("WIN_DEPTH must be at least 2"); end
      if (MAX_NODES < 1)         begin : g_bad_nodes  $error("MAX_NODES must be at least 1"); end
      if (MAX_NODES > NUM_SLOTS) begin : g_bad_fit    $error("MAX_NODES cannot exceed NUM_SLOTS"); end
      if (NUM_CPL < 1)           begin : g_bad_cpl    $error("NUM_CPL must be at least 1"); end
   endgenerate

   logic [TAG_W-1:0]     ptr;
   logic [FREE_W-1:0]    free_cnt;
   logic [NUM_SLOTS-1:0] done;
   logic                 win_full, head_valid, head_exec, grant;
   logic [TAG_W-1:0]     head_base;
   logic [CNT_W-1:0]     head_cnt;

   // Admission: enough free slots and a free window entry.
   always_comb begin
      alloc_stall = alloc_req &&
                    ((FREE_W'(alloc_cnt) > free_cnt) || win_full);
      grant       = alloc_req && !alloc_stall;
   end

   tagq_ring #(
      .NUM_SLOTS (NUM_SLOTS),
      .MAX_NODES (MAX_NODES),
      .TAG_W     (TAG_W),
      .CNT_W     (CNT_W),
      .FREE_W    (FREE_W)
   ) u_ring (
      .clk       (clk),
      .rst_n     (rst_n),
      .take_en   (grant),
      .take_cnt  (alloc_cnt),
      .give_en   (retire_valid),
      .give_cnt  (retire_cnt),
      .ptr       (ptr),
      .lane_tags (alloc_tags),
      .free_cnt  (free_cnt)
   );

   tagq_done #(
      .NUM_SLOTS (NUM_SLOTS),
      .NUM_CPL   (NUM_CPL),
      .TAG_W     (TAG_W),
      .CNT_W     (CNT_W)
   ) u_done (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_en    (grant),
      .clr_base  (ptr),
      .clr_cnt   (alloc_cnt),
      .cpl_valid (cpl_valid),
      .cpl_tag   (cpl_tag),
      .done      (done)
   );

   tagq_window #(
      .WIN_DEPTH (WIN_DEPTH),
      .TAG_W     (TAG_W),
      .CNT_W     (CNT_W)
   ) u_win (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (grant),
      .push_base  (ptr),
      .push_cnt   (alloc_cnt),
      .pop        (retire_valid),
      .head_valid (head_valid),
      .head_base  (head_base),
      .head_cnt   (head_cnt),
      .full       (win_full)
   );

   // Oldest instruction is executed when each of its nodes is done.
   always_comb begin
      head_exec = 1'b1;
      for (int i = 0; i < MAX_NODES; i++) begin
         if ((i < int'(head_cnt)) &&
             !done[TAG_W'(ring_add(int'(head_base), i, NUM_SLOTS))])
            head_exec = 1'b0;
      end
   end

   assign retire_valid = head_valid && head_exec;
   assign retire_base  = head_base;
   assign retire_cnt   = head_cnt;

   AST_REQ_COUNT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_req |-> ((alloc_cnt != '0) && (int'(alloc_cnt) <= MAX_NODES))); // R2

   AST_STALL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_stall |-> alloc_req); // R3

   AST_STALL_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      alloc_stall |=> (ptr == $past(ptr))); // R3

   AST_RETIRE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
      retire_valid |->
         (retire_base == TAG_W'(ring_add(int'(ptr), int'(free_cnt), NUM_SLOTS)))); // R6

   AST_RETIRE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_valid && !grant) |=>
         (free_cnt == $past(free_cnt) + FREE_W'($past(retire_cnt)))); // R8

   AST_RETIRE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      retire_valid |-> (retire_cnt != '0)); // R7

endmodule

// File: tb/tagq_alloc_bench.sv
module tagq_alloc_bench;

   localparam int NS = 10;
   localparam int WD = 4;
   localparam int MN = 3;
   localparam int NC = 2;
   localparam int TW = 4;
   localparam int CW = 2;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              alloc_req = 1'b0;
   logic [CW-1:0]     alloc_cnt = '0;
   logic              alloc_stall;
   logic [MN*TW-1:0]  alloc_tags;
   logic [NC-1:0]     cpl_valid = '0;
   logic [NC*TW-1:0]  cpl_tag = '0;
   logic              retire_valid;
   logic [TW-1:0]     retire_base;
   logic [CW-1:0]     retire_cnt;

   always #5 clk = ~clk;

   tagq_alloc #(
      .NUM_SLOTS (NS),
      .WIN_DEPTH (WD),
      .MAX_NODES (MN),
      .NUM_CPL   (NC)
   ) u_tagq_alloc (
      .clk          (clk),
      .rst_n        (rst_n),
      .alloc_req    (alloc_req),
      .alloc_cnt    (alloc_cnt),
      .alloc_stall  (alloc_stall),
      .alloc_tags   (alloc_tags),
      .cpl_valid    (cpl_valid),
      .cpl_tag      (cpl_tag),
      .retire_valid (retire_valid),
      .retire_base  (retire_base),
      .retire_cnt   (retire_cnt)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   // Model of the requirements
   int m_ptr, m_free, m_occ, m_head, m_tail;
   int w_base [WD];
   int w_cnt  [WD];
   bit m_done [NS];
   bit m_used [NS];
   int n_stall, n_retire, n_wrap;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic model_reset();
      m_ptr = 0; m_free = NS; m_occ = 0; m_head = 0; m_tail = 0;
      for (int s = 0; s < NS; s++) begin m_done[s] = 0; m_used[s] = 0; end
   endtask

   function automatic bit head_ready();
      if (m_occ == 0) return 1'b0;
      for (int i = 0; i < w_cnt[m_head]; i++)
         if (!m_done[(w_base[m_head] + i) % NS]) return 1'b0;
      return 1'b1;
   endfunction

   // One cycle: drive, check outputs, advance the model at the edge.
   task automatic step(input bit req, input int cnt,
                       input bit v0, input int t0, input bit v1, input int t1);
      bit exp_stall, exp_ret, grant;
      @(negedge clk);
      alloc_req = req;
      alloc_cnt = CW'(cnt);
      cpl_valid = {v1, v0};
      cpl_tag   = {TW'(t1), TW'(t0)};
      #1;
      exp_stall = req && ((cnt > m_free) || (m_occ == WD));
      chk(alloc_stall == exp_stall, "R3 R4 R8 stall", int'(alloc_stall), int'(exp_stall));
      grant = req && !exp_stall;
      if (grant) begin
         for (int i = 0; i < cnt; i++)
            chk(int'(alloc_tags[i*TW +: TW]) == (m_ptr + i) % NS, "R2 tag",
                int'(alloc_tags[i*TW +: TW]), (m_ptr + i) % NS);
         if (m_ptr + cnt > NS) n_wrap++;
      end
      if (exp_stall) n_stall++;
      exp_ret = head_ready();
      chk(retire_valid == exp_ret, "R5 R6 R7 R9 retire", int'(retire_valid), int'(exp_ret));
      if (exp_ret) begin
         chk(int'(retire_base) == w_base[m_head], "R7 base", int'(retire_base), w_base[m_head]);
         chk(int'(retire_cnt) == w_cnt[m_head], "R7 count", int'(retire_cnt), w_cnt[m_head]);
         n_retire++;
      end
      @(posedge clk);
      if (exp_ret) begin
         for (int i = 0; i < w_cnt[m_head]; i++) m_used[(w_base[m_head] + i) % NS] = 0;
         m_free += w_cnt[m_head];
         m_head = (m_head + 1) % WD;
         m_occ--;
      end
      if (v0) m_done[t0] = 1;
      if (v1) m_done[t1] = 1;
      if (grant) begin
         for (int i = 0; i < cnt; i++) begin
            m_done[(m_ptr + i) % NS] = 0;
            m_used[(m_ptr + i) % NS] = 1;
         end
         w_base[m_tail] = m_ptr;
         w_cnt[m_tail]  = cnt;
         m_tail = (m_tail + 1) % WD;
         m_occ++;
         m_free -= cnt;
         m_ptr = (m_ptr + cnt) % NS;
      end
   endtask

   task automatic idle();
      step(0, 1, 0, 0, 0, 0);
   endtask

   // Pick up to two in-flight, unreported slots starting at a scan point.
   task automatic pick(input int start, output bit v0, output int t0,
                       output bit v1, output int t1);
      v0 = 0; v1 = 0; t0 = 0; t1 = 0;
      for (int j = 0; j < NS; j++) begin
         int s;
         s = (start + j) % NS;
         if (m_used[s] && !m_done[s]) begin
            if (!v0) begin v0 = 1; t0 = s; end
            else if (!v1) begin v1 = 1; t1 = s; end
         end
      end
   endtask

   task automatic drain();
      for (int n = 0; n < 40 && m_occ != 0; n++) begin
         bit v0, v1;
         int t0, t1;
         pick(m_ptr, v0, t0, v1, t1);
         step(0, 1, v0, t0, v1, t1);
      end
      chk(m_occ == 0, "R5 drain", m_occ, 0);
   endtask

   initial begin
      int lfsr;
      model_reset();
      n_stall = 0; n_retire = 0; n_wrap = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(retire_valid == 1'b0, "R1 no retire after reset", int'(retire_valid), 0);
      chk(alloc_stall == 1'b0, "R1 no stall after reset", int'(alloc_stall), 0);

      // R1 R2: first grants start at tag 0
      step(1, 3, 0, 0, 0, 0);
      step(1, 2, 0, 0, 0, 0);
      step(1, 1, 0, 0, 0, 0);
      // R6: younger instruction finishes first, oldest holds it back
      step(0, 1, 1, 3, 1, 4);
      idle();
      chk(m_occ == 3, "R6 nothing retired yet", m_occ, 3);
      // R5 R9: two completions in one cycle, one node still missing
      step(0, 1, 1, 0, 1, 2);
      idle();
      step(0, 1, 1, 1, 0, 0);
      // R7: two executed instructions retire on successive cycles
      idle();
      idle();
      idle();
      step(0, 1, 1, 5, 0, 0);
      idle();
      chk(m_occ == 0, "R7 all retired", m_occ, 0);

      // R4: window full with free slots remaining
      for (int i = 0; i < WD; i++) step(1, 1, 0, 0, 0, 0);
      step(1, 1, 0, 0, 0, 0);
      chk(m_free > 0, "R4 slots were free", m_free, 1);
      // R8: retire releases an entry, next request granted
      step(0, 1, 1, 6, 0, 0);
      step(1, 1, 0, 0, 0, 0);
      step(1, 1, 0, 0, 0, 0);
      drain();

      // R3: slot shortage with window room
      step(1, 3, 0, 0, 0, 0);
      step(1, 3, 0, 0, 0, 0);
      step(1, 3, 0, 0, 0, 0);
      step(1, 3, 0, 0, 0, 0);
      step(1, 2, 0, 0, 0, 0);
      step(1, 1, 0, 0, 0, 0);
      drain();

      // Sweep of request and completion patterns
      lfsr = 32'h1ACE;
      for (int c = 0; c < 4000; c++) begin
         bit v0, v1, rq;
         int t0, t1, cn;
         lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
         rq = ((lfsr >> 3) & 3) != 0;
         cn = 1 + ((lfsr >> 5) % MN);
         pick((lfsr >> 7) % NS, v0, t0, v1, t1);
         if (((lfsr >> 11) & 1) != 0) v1 = 0;
         if (((lfsr >> 12) & 3) == 0) v0 = 0;
         step(rq, cn, v0, t0, v1, t1);
      end
      drain();
      chk(n_stall > 0, "R3 stall seen", n_stall, 1);
      chk(n_wrap > 0, "R2 wrap seen", n_wrap, 1);
      chk(n_retire > 0, "R7 retire seen", n_retire, 1);

      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule